// File: doc/BRIEF.md
# Single-Step Non-Restoring Division Unit

This block performs one step of a 32-bit non-restoring division per request. Each step shifts the partial remainder left by one bit. The incoming quotient bit (the T flag) enters at bit 0. The step then either adds or subtracts the divisor and regenerates the sign-tracking flag Q and the quotient flag T. The divisor-sign flag M is read by the step and never written by it. A full quotient takes 32 steps issued by an outer sequencer. That sequencer, and the signed or unsigned setup that comes before it, sit outside this block.

The wrapper holds Q, M and T between steps. It registers the new partial remainder, which the caller feeds back through `rem_i` on the next step. An init strobe loads Q, M and T directly. The outer sequence uses this path to set the start-of-division state. It also uses it to place a new value in T between steps, for example when the dividend is rotated through T.

Control picks one of three operations each cycle, decoded by a unique case:
- DS_LOAD: `init_i` is high. The three flags are loaded and the remainder is held. This operation wins over a step.
- DS_STEP: `step_i` is high and `init_i` is low. One division step is committed.
- DS_HOLD: neither strobe is high. All state is kept.

Every cycle moves to whichever operation its strobes select. No operation depends on the one before it.

Top module: `divstep_unit`

## Requirements
- R1: After reset, `rem_o`, `q_o`, `m_o` and `t_o` are all zero.
- R2: With `init_i` high, the next clock edge loads `q_o`, `m_o`, `t_o` from `init_q_i`, `init_m_i`, `init_t_i` and leaves `rem_o` unchanged, even if `step_i` is also high.
- R3: With both strobes low, `rem_o`, `q_o`, `m_o` and `t_o` keep their values, whatever `rem_i` and `divisor_i` do.
- R4: A step forms the shifted operand as `rem_i` shifted left by one, with the current T placed in bit 0; the top bit of `rem_i` is dropped from the operand.
- R5: If the current Q equals M, a step subtracts `divisor_i` from the shifted operand; otherwise it adds it. The result, modulo 2^32, appears on `rem_o` after the edge.
- R6: A step sets the new Q to bit 31 of `rem_i` XOR the carry term XOR M. For a subtraction the carry term is the borrow, meaning the result is unsigned-greater than the shifted operand. For an addition it is the carry-out, meaning the result is unsigned-less than the shifted operand.
- R7: After a step, `t_o` is 1 exactly when the new Q equals M.
- R8: A step never changes `m_o`.
- R9: The unsigned procedure divides any 32-bit dividend by any nonzero 32-bit divisor. Start with Q=M=T=0 and remainder 0. Before each of 32 steps, rotate the dividend left through T. Rotate once more after the last step. The dividend register then holds the unsigned quotient.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| init_i | input | 1 | Load the three flags from the init inputs |
| init_q_i | input | 1 | Value loaded into Q |
| init_m_i | input | 1 | Value loaded into M |
| init_t_i | input | 1 | Value loaded into T |
| step_i | input | 1 | Commit one division step |
| rem_i | input | 32 | Partial remainder operand for this step |
| divisor_i | input | 32 | Divisor operand |
| rem_o | output | 32 | Registered partial remainder from the last step |
| q_o | output | 1 | Current Q flag |
| m_o | output | 1 | Current M flag |
| t_o | output | 1 | Current T flag |

## Verification
A vector table drives single steps through all four pairs of old Q and M, with T both clear and set.

The operands are chosen so that each path meets both a zero and a nonzero carry term. This separates the subtract and add selections and the XOR with the top remainder bit. It also catches an inverted borrow or carry test. Some vectors wrap to zero or run past the top, so a carry rule based on the wrong comparison shows up at once.

The full 32-step unsigned procedure then runs on random operands and on extreme ones: an all-ones dividend, a divisor of one, an all-ones divisor and a zero dividend. This confirms that the steps chain into the correct quotient. Directed cycles with both strobes low, and with both strobes high, check the hold and priority rules.

// File: rtl/divstep_pkg.sv
package divstep_pkg;

    localparam int unsigned DS_WIDTH = 32;

    typedef struct packed {
        logic q;
        logic m;
        logic t;
    } ds_flags_t;

    typedef enum logic [1:0] {
        DS_HOLD = 2'd0,
        DS_LOAD = 2'd1,
        DS_STEP = 2'd2
    } ds_op_e;

endpackage

// File: rtl/divstep_addsub.sv
module divstep_addsub #(
    parameter int unsigned W = 32,
    parameter bit CARRY_FROM_COMPARE = 1'b0
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         sub_i,
    output logic [W-1:0] sum_o,
    output logic         cy_o
);

    generate
        if (CARRY_FROM_COMPARE) begin : g_cmp
            always_comb begin
                sum_o = sub_i ? (a_i - b_i) : (a_i + b_i);
                cy_o  = sub_i ? (sum_o > a_i) : (sum_o < a_i);
            end
        end else begin : g_ext
            logic [W:0] ext;
            always_comb begin
                ext   = {1'b0, a_i} + {1'b0, (sub_i ? ~b_i : b_i)} + {{W{1'b0}}, sub_i};
                sum_o = ext[W-1:0];
                // adding the complement: carry out set means no borrow
                cy_o  = sub_i ? ~ext[W] : ext[W];
            end
        end
    endgenerate

    always_comb begin
        if (!$isunknown({a_i, b_i, sub_i})) begin
            AST_ADDSUB_INVERSE: assert (sub_i ? ((sum_o + b_i) == a_i) : ((sum_o - b_i) == a_i))
                else $error("add/sub result does not invert"); // R5
        end
    end

endmodule

// File: rtl/divstep_core.sv
module divstep_core
    import divstep_pkg::*;
#(
    parameter int unsigned W = DS_WIDTH
) (
    input  logic [W-1:0] rem_i,
    input  logic [W-1:0] dvsr_i,
    input  ds_flags_t    flags_i,
    output logic [W-1:0] rem_o,
    output ds_flags_t    flags_o
);

    logic         top_bit;
    logic [W-1:0] shifted;
    logic         do_sub;
    logic         cy;
    logic         q_new;

    assign top_bit = rem_i[W-1];
    assign shifted = {rem_i[W-2:0], flags_i.t};
    assign do_sub  = (flags_i.q == flags_i.m);

    divstep_addsub #(
        .W                  (W),
        .CARRY_FROM_COMPARE (1'b0)
    ) u_addsub (
        .a_i   (shifted),
        .b_i   (dvsr_i),
        .sub_i (do_sub),
        .sum_o (rem_o),
        .cy_o  (cy)
    );

    always_comb begin
        unique case ({flags_i.q, flags_i.m})
            2'b00:   q_new = top_bit ^ cy;
            2'b01:   q_new = ~(top_bit ^ cy);
            2'b10:   q_new = top_bit ^ cy;
            default: q_new = ~(top_bit ^ cy);
        endcase
        flags_o.q = q_new;
        flags_o.m = flags_i.m;
        flags_o.t = (q_new == flags_i.m);
    end

    always_comb begin
        if (!$isunknown({rem_i, flags_i})) begin
            AST_SHIFT_LSB: assert (shifted[0] == flags_i.t && shifted[W-1:1] == rem_i[W-2:0])
                else $error("shift operand malformed"); // R4
        end
    end

endmodule

// File: rtl/divstep_unit.sv
module divstep_unit
    import divstep_pkg::*;
#(
    parameter int unsigned W = DS_WIDTH
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         init_i,
    input  logic         init_q_i,
    input  logic         init_m_i,
    input  logic         init_t_i,
    input  logic         step_i,
    input  logic [W-1:0] rem_i,
    input  logic [W-1:0] divisor_i,
    output logic [W-1:0] rem_o,
    output logic         q_o,
    output logic         m_o,
    output logic         t_o
);

    ds_op_e       op;
    ds_flags_t    flags_q;
    ds_flags_t    flags_next;
    logic [W-1:0] rem_q;
    logic [W-1:0] rem_next;

    divstep_core #(.W(W)) u_core (
        .rem_i   (rem_i),
        .dvsr_i  (divisor_i),
        .flags_i (flags_q),
        .rem_o   (rem_next),
        .flags_o (flags_next)
    );

    // operation select: init outranks step
    always_comb begin
        if (init_i)      op = DS_LOAD;
        else if (step_i) op = DS_STEP;
        else             op = DS_HOLD;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags_q <= '0;
            rem_q   <= '0;
        end else begin
            unique case (op)
                DS_LOAD: flags_q <= '{q: init_q_i, m: init_m_i, t: init_t_i};
                DS_STEP: begin
                    flags_q <= flags_next;
                    rem_q   <= rem_next;
                end
                default: ;
            endcase
        end
    end

    assign rem_o = rem_q;
    assign q_o   = flags_q.q;
    assign m_o   = flags_q.m;
    assign t_o   = flags_q.t;

    AST_INIT_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        init_i |=> (q_o == $past(init_q_i) && m_o == $past(init_m_i) && t_o == $past(init_t_i)))
        else $error("init did not load flags"); // R2
    AST_INIT_KEEPS_REM: assert property (@(posedge clk) disable iff (!rst_n)
        init_i |=> $stable(rem_o))
        else $error("init changed remainder"); // R2
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!init_i && !step_i) |=> ($stable(rem_o) && $stable(q_o) && $stable(m_o) && $stable(t_o)))
        else $error("state moved while idle"); // R3
    AST_STEP_KEEPS_M: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !init_i) |=> $stable(m_o))
        else $error("step changed M"); // R8
    AST_T_IS_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !init_i) |=> (t_o == (q_o == m_o)))
        else $error("T does not reflect Q==M"); // R7

endmodule

// File: tb/sim_divstep_unit.sv
module sim_divstep_unit;

    localparam int NV = 10;
    localparam logic [31:0] V_REM [NV] = '{32'h00000005, 32'h00000001, 32'h80000000, 32'hFFFFFFFF,
        32'hFFFFFFFF, 32'h00000010, 32'h00000010, 32'h40000000, 32'h00000000, 32'h12345678};
    localparam logic [31:0] V_DIV [NV] = '{32'h3, 32'h3, 32'h1, 32'h1, 32'h2,
        32'hFFFFFFF0, 32'h4, 32'h80000000, 32'h1, 32'h0};
    // {Q,M,T} before the step
    localparam logic [2:0] V_QMT [NV] = '{3'b000, 3'b000, 3'b001, 3'b100, 3'b100,
        3'b010, 3'b011, 3'b110, 3'b110, 3'b001};
    localparam logic [31:0] E_REM [NV] = '{32'h00000007, 32'hFFFFFFFF, 32'h00000000, 32'hFFFFFFFF,
        32'h00000000, 32'h00000010, 32'h00000025, 32'h00000000, 32'hFFFFFFFF, 32'h2468ACF1};
    // {Q,T} after the step
    localparam logic [1:0] E_QT [NV] = '{2'b01, 2'b10, 2'b10, 2'b10, 2'b01,
        2'b00, 2'b11, 2'b11, 2'b00, 2'b01};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        init_i = 1'b0, init_q_i = 1'b0, init_m_i = 1'b0, init_t_i = 1'b0;
    logic        step_i = 1'b0;
    logic [31:0] rem_i = '0, divisor_i = '0;
    logic [31:0] rem_o;
    logic        q_o, m_o, t_o;
    int          n_run = 0, n_fail = 0;

    always #4 clk = ~clk;

    divstep_unit u0 (
        .clk(clk), .rst_n(rst_n), .init_i(init_i), .init_q_i(init_q_i), .init_m_i(init_m_i),
        .init_t_i(init_t_i), .step_i(step_i), .rem_i(rem_i), .divisor_i(divisor_i),
        .rem_o(rem_o), .q_o(q_o), .m_o(m_o), .t_o(t_o)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_init(input logic q, input logic m, input logic t);
        @(negedge clk);
        init_i = 1'b1; init_q_i = q; init_m_i = m; init_t_i = t;
        @(negedge clk);
        init_i = 1'b0;
    endtask

    task automatic do_step(input logic [31:0] r, input logic [31:0] d);
        @(negedge clk);
        rem_i = r; divisor_i = d; step_i = 1'b1;
        @(negedge clk);
        step_i = 1'b0;
    endtask

    task automatic run_div(input logic [31:0] a, input logic [31:0] b);
        logic [31:0] dvd;
        logic [31:0] r;
        logic        t;
        dvd = a; r = '0; t = 1'b0;
        do_init(1'b0, 1'b0, 1'b0);
        for (int i = 0; i < 32; i++) begin
            logic nt;
            nt  = dvd[31];
            dvd = {dvd[30:0], t};
            do_init(q_o, m_o, nt);
            do_step(r, b);
            r = rem_o;
            t = t_o;
        end
        dvd = {dvd[30:0], t};
        check($sformatf("R9 quotient %h/%h", a, b), dvd, a / b);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] keep_rem;
        logic [31:0] ra, rb;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset rem_o", rem_o, 32'h0);
        check("R1 reset flags", {29'd0, q_o, m_o, t_o}, 32'h0);

        // single steps from the table: R4 R5 R6 R7 R8
        for (int k = 0; k < NV; k++) begin
            do_init(V_QMT[k][2], V_QMT[k][1], V_QMT[k][0]);
            do_step(V_REM[k], V_DIV[k]);
            check($sformatf("R4/R5 vec%0d rem", k), rem_o, E_REM[k]);
            check($sformatf("R6/R7 vec%0d qt", k), {30'd0, q_o, t_o}, {30'd0, E_QT[k]});
            check($sformatf("R8 vec%0d m", k), {31'd0, m_o}, {31'd0, V_QMT[k][1]});
        end

        // R3: idle cycles with moving operands
        keep_rem = rem_o;
        @(negedge clk); rem_i = 32'hA5A5A5A5; divisor_i = 32'h1;
        repeat (3) @(negedge clk);
        check("R3 idle rem", rem_o, keep_rem);
        check("R3 idle flags", {29'd0, q_o, m_o, t_o}, 32'h1);

        // R2: init and step together, init wins and remainder holds
        @(negedge clk);
        init_i = 1'b1; step_i = 1'b1; init_q_i = 1'b1; init_m_i = 1'b0; init_t_i = 1'b1;
        rem_i = 32'h00000005; divisor_i = 32'h3;
        @(negedge clk);
        init_i = 1'b0; step_i = 1'b0;
        check("R2 priority flags", {29'd0, q_o, m_o, t_o}, 32'h5);
        check("R2 priority rem", rem_o, keep_rem);
        do_init(1'b0, 1'b1, 1'b0);
        check("R2 init load", {29'd0, q_o, m_o, t_o}, 32'h2);

        // R9: full divisions
        run_div(32'd100, 32'd7);
        run_div(32'hFFFFFFFF, 32'd1);
        run_div(32'hFFFFFFFF, 32'hFFFFFFFF);
        run_div(32'd0, 32'd7);
        run_div(32'h80000000, 32'h80000001);
        for (int j = 0; j < 20; j++) begin
            ra = $urandom;
            rb = $urandom >> (j % 31);
            if (rb == 0) rb = 32'd3;
            run_div(ra, rb);
        end

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule